// File: doc/BRIEF.md
# Serial Command Receive Port

This block is the slave side of a four-wire serial control link. A host selects the device by pulling an active-low select line, then toggles a serial clock and presents one data bit per rising edge. The block samples the three host lines with a fast system clock, finds the clock edges, and assembles a 16-bit command word with the most significant bit arriving first. When the sixteenth bit has been captured, the word is offered to the downstream register block on a valid/ready stream.

In the same transfer, the block returns two status flags on the serial data-out line. These are a FIFO-level flag followed by an overflow flag. It takes a snapshot of them when select falls and shifts them out on the falling clock edges. Raising select at any point clears the bit counter and the shift register, and a partial command is thrown away. After the sixteenth bit, further bits in the same frame are ignored. The command decoder can therefore use only the bits its code needs and leave the rest as don't-care padding.

The output stream uses valid/ready with back-pressure. A word stays on `cmd_word_o` with `cmd_valid_o` high until the consumer raises `cmd_ready_i`. The serial link cannot be stalled, so a frame that completes while the previous word is still waiting is dropped. The system clock must run at least four times faster than the serial clock. Each serial clock phase must last at least two system clock periods.

Top module: `serial_cmd_port`

## Requirements
- R1: A data bit is captured only on a rising edge of the serial clock while select is low. Clock activity while select is high has no effect on the next received word.
- R2: The first bit clocked in after select falls becomes bit 15 of `cmd_word_o`, and the last of sixteen becomes bit 0.
- R3: Raising select before sixteen bits have been captured discards them. The following frame is assembled from an empty shifter.
- R4: When the sixteenth bit is captured, the word is offered with `cmd_valid_o` high. Bits beyond the sixteenth in the same frame are ignored, and each frame yields at most one word.
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` stays high and `cmd_word_o` does not change. A frame completing during that time is dropped.
- R6: While select is low, `sdo_o` first shows `stat_i[1]` (FIFO flag). After the first falling serial clock edge it shows `stat_i[0]` (overflow flag). It shows 0 after every later falling edge.
- R7: `sdo_o` is 0 while select is high.
- R8: After reset, `cmd_valid_o` is 0, `cmd_word_o` is 0 and `sdo_o` is 0.
- R9: The status flags are captured when select falls. Changes to `stat_i` later in the frame do not alter the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host, idle low |
| sel_n_i | input | 1 | Active-low frame select from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial status data to the host |
| stat_i | input | 2 | Status flags: [1] FIFO flag, [0] overflow flag |
| cmd_valid_o | output | 1 | Command word offered |
| cmd_ready_i | input | 1 | Consumer accepts the offered word |
| cmd_word_o | output | 16 | Assembled command word |

## Verification
The hardest case to reach is a frame that completes while the previous word is still waiting under back-pressure. This needs a whole second serial frame to run while the consumer holds ready low. The bench holds `cmd_ready_i` low across two complete frames. It then checks that the first word is still presented unchanged and is accepted exactly once, and that the second word never appears. The status ordering is also tricky to reach, because it depends on SDO being sampled between falling edges. The bench drives single clock pulses by hand and samples SDO at the end of each low phase. It also changes `stat_i` in the middle of the frame to confirm that the snapshot holds.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int CMD_W_DEF  = 16;
  localparam int STAT_W_DEF = 2;
  localparam int SYNC_DEF   = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_edge.sv
module scp_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig,
  output scp_pkg::edge_t ed
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= sig;
  end

  always_comb begin
    ed.rise = sig & ~prev;
    ed.fall = ~sig & prev;
  end
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int CMD_W = 16,
  localparam int CNT_W = $clog2(CMD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_q,
  input  logic             sck_rise,
  input  logic             sdi_q,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             done,
  output logic [CMD_W-1:0] word
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);

  logic [CMD_W-1:0] sh;
  logic             take;

  assign take = sck_rise & ~sel_q & (bit_cnt != FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
      done    <= 1'b0;
    end else if (sel_q) begin
      sh      <= '0;
      bit_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= take & (bit_cnt == LAST);
      if (take) begin
        sh      <= {sh[CMD_W-2:0], sdi_q};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign word = sh;
endmodule

// File: rtl/scp_status_tx.sv
module scp_status_tx #(
  parameter int STAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_q,
  input  logic              sel_fall,
  input  logic              sck_fall,
  input  logic [STAT_W-1:0] stat,
  output logic              sdo
);
  logic [STAT_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else begin
      if (sel_q)         sh <= '0;
      else if (sel_fall) sh <= stat;
      else if (sck_fall) sh <= sh << 1;
      sdo <= sel_q ? 1'b0 : sh[STAT_W-1];
    end
  end
endmodule

// File: rtl/scp_out_buf.sv
module scp_out_buf #(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] din,
  output logic             valid,
  input  logic             ready,
  output logic [CMD_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load && (!valid || ready)) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port #(
  parameter int CMD_W  = scp_pkg::CMD_W_DEF,
  parameter int STAT_W = scp_pkg::STAT_W_DEF,
  parameter int SYNC   = scp_pkg::SYNC_DEF,
  localparam int CNT_W = $clog2(CMD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sel_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [STAT_W-1:0] stat_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CMD_W-1:0]  cmd_word_o
);
  logic [2:0]       pins_q;
  logic             sck_q, sel_q, sdi_q;
  scp_pkg::edge_t   sck_ed, sel_ed;
  logic [CNT_W-1:0] bit_cnt;
  logic             word_done;
  logic [CMD_W-1:0] word;

  scp_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, sel_n_i, sdi_i}), .q(pins_q)
  );
  assign {sck_q, sel_q, sdi_q} = pins_q;

  scp_edge #(.RST_VAL(1'b0)) u_sck_ed (
    .clk(clk), .rst_n(rst_n), .sig(sck_q), .ed(sck_ed)
  );
  scp_edge #(.RST_VAL(1'b1)) u_sel_ed (
    .clk(clk), .rst_n(rst_n), .sig(sel_q), .ed(sel_ed)
  );

  scp_shifter #(.CMD_W(CMD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .sck_rise(sck_ed.rise),
    .sdi_q(sdi_q), .bit_cnt(bit_cnt), .done(word_done), .word(word)
  );

  scp_status_tx #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .sel_fall(sel_ed.fall),
    .sck_fall(sck_ed.fall), .stat(stat_i), .sdo(sdo_o)
  );

  scp_out_buf #(.CMD_W(CMD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(word_done), .din(word),
    .valid(cmd_valid_o), .ready(cmd_ready_i), .dout(cmd_word_o)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int CMD_W = 16,
  localparam int CNT_W = $clog2(CMD_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_q,
  input logic             word_done,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdo_o,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic [CMD_W-1:0] cmd_word_o
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_word_o));

  // R7
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> !sdo_o);

  // R3
  deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> bit_cnt == '0);

  // R4
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CMD_W));

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> $past(word_done));
endmodule

bind serial_cmd_port scp_checker #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .word_done(word_done),
  .bit_cnt(bit_cnt), .sdo_o(sdo_o), .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o)
);

// File: tb/test_serial_cmd_port.sv
module test_serial_cmd_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sel_n = 1'b1, sdi = 1'b0, sdo;
  logic [1:0] stat = 2'b00;
  logic cmd_valid, cmd_ready = 1'b1;
  logic [15:0] cmd_word;
  int checks = 0, errors = 0;
  int rx_count = 0;
  logic [15:0] rx_last = '0;

  localparam int HALF = 5;

  always #5 clk = ~clk;

  serial_cmd_port i_serial_cmd_port (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n), .sdi_i(sdi),
    .sdo_o(sdo), .stat_i(stat), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready), .cmd_word_o(cmd_word)
  );

  always @(posedge clk) if (cmd_valid && cmd_ready) begin
    rx_count <= rx_count + 1;
    rx_last  <= cmd_word;
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulse(input logic b);
    sdi = b; clks(HALF);
    sck = 1'b1; clks(HALF);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    sel_n = 1'b0; clks(HALF);
    for (int i = n - 1; i >= 0; i--) sck_pulse(bits[i]);
    clks(HALF);
    sel_n = 1'b1; clks(12);
  endtask

  task automatic t_reset();
    check(cmd_valid == 1'b0, "R8 valid", 32'(cmd_valid), 0);
    check(cmd_word == 16'h0, "R8 word", 32'(cmd_word), 0);
    check(sdo == 1'b0, "R8 sdo", 32'(sdo), 0);
  endtask

  task automatic t_basic(input logic [15:0] w);
    int c0 = rx_count;
    frame(32'(w), 16);
    check(rx_count == c0 + 1, "R4 one word", 32'(rx_count - c0), 1);
    check(rx_last == w, "R2 msb first word", 32'(rx_last), 32'(w));
  endtask

  task automatic t_abort();
    int c0 = rx_count;
    frame(32'h1FF, 9);
    check(rx_count == c0, "R3 partial dropped", 32'(rx_count - c0), 0);
    frame(32'h1234, 16);
    check(rx_last == 16'h1234, "R3 fresh frame", 32'(rx_last), 32'h1234);
  endtask

  task automatic t_idle_clock();
    int c0 = rx_count;
    for (int i = 0; i < 5; i++) sck_pulse(1'b1);
    clks(8);
    check(rx_count == c0, "R1 no capture deselected", 32'(rx_count - c0), 0);
    frame(32'h0F0F, 16);
    check(rx_last == 16'h0F0F, "R1 clean word", 32'(rx_last), 32'h0F0F);
  endtask

  task automatic t_long();
    int c0 = rx_count;
    frame(32'hC3A5_7E, 24);
    check(rx_count == c0 + 1, "R4 single word long frame", 32'(rx_count - c0), 1);
    check(rx_last == 16'hC3A5, "R4 extra bits ignored", 32'(rx_last), 32'hC3A5);
  endtask

  task automatic t_status(input logic [1:0] s);
    stat = s;
    check(sdo == 1'b0, "R7 sdo idle", 32'(sdo), 0);
    sel_n = 1'b0; clks(8);
    stat = ~s; // R9 snapshot must hold
    check(sdo == s[1], "R6 first status bit", 32'(sdo), 32'(s[1]));
    sck_pulse(1'b0); clks(HALF);
    check(sdo == s[0], "R6 R9 second status bit", 32'(sdo), 32'(s[0]));
    sck_pulse(1'b0); clks(HALF);
    check(sdo == 1'b0, "R6 zero fill", 32'(sdo), 0);
    sel_n = 1'b1; clks(12);
    check(sdo == 1'b0, "R7 sdo after deselect", 32'(sdo), 0);
  endtask

  task automatic t_backpressure();
    int c0 = rx_count;
    cmd_ready = 1'b0;
    frame(32'hBEEF, 16);
    check(cmd_valid == 1'b1, "R5 valid held", 32'(cmd_valid), 1);
    check(cmd_word == 16'hBEEF, "R5 word held", 32'(cmd_word), 32'hBEEF);
    frame(32'h5555, 16);
    check(cmd_word == 16'hBEEF, "R5 second frame dropped", 32'(cmd_word), 32'hBEEF);
    cmd_ready = 1'b1; clks(4);
    check(rx_count == c0 + 1, "R5 accepted once", 32'(rx_count - c0), 1);
    check(rx_last == 16'hBEEF, "R5 accepted word", 32'(rx_last), 32'hBEEF);
    check(cmd_valid == 1'b0, "R5 valid cleared", 32'(cmd_valid), 0);
  endtask

  task automatic run_all();
    clks(4); rst_n = 1'b1; clks(4);
    t_reset();
    t_basic(16'hA5C3);
    t_basic(16'h0001);
    t_basic(16'hFFFF);
    t_abort();
    t_idle_clock();
    t_long();
    t_status(2'b10);
    t_status(2'b01);
    t_backpressure();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule